// File: doc/BRIEF.md
# Integrating Overcurrent Hiccup Controller

This block decides when repeated overcurrent should stop a switching converter and when the converter may try again. A digital accumulator stands in for a fault-timing capacitor. On every oscillator tick where the per-cycle current-limit flag is set, a programmable charge quantum is added. On every tick, a programmable leak is drained. Both operations saturate, so the value never wraps.

While running, isolated current-limit trips are tolerated, and cycle-by-cycle limiting continues elsewhere. The block acts only when the integrated value reaches the upper threshold. It then raises a shutdown flag.

While shut down, new current-limit events add nothing, and only the leak lowers the level. When the level falls to the lower threshold, the shutdown flag clears and a one-clock restart pulse asks the converter to run a full soft-start again. For a hiccup duty of about one in ten, size the leak so that recovery takes roughly ten times as long as the charge-up.

Top module: `hiccup_integrator`

## Requirements
- R1: While reset (active-low, asynchronous) is applied and at its release, `level` is 0, `shutdown` is 0 and `restart` is 0.
- R2: On a clock edge where `tick` is 0, `level`, `shutdown` and `restart` hold their values, except that `restart` returns to 0.
- R3: On a tick while running, the new level is computed in two steps. First the level gains `cfg_step` if `ilim_hit` is 1, saturating at 2^ACC_W-1. Then it loses `cfg_leak`, saturating at 0. The result is visible the clock after the tick edge.
- R4: `shutdown` goes to 1 at the tick edge whose new level is greater than or equal to `cfg_hi`.
- R5: While `shutdown` is 1, `ilim_hit` has no effect. Each tick only subtracts `cfg_leak`, saturating at 0.
- R6: While shut down, at the tick edge whose new level is less than or equal to `cfg_lo`, `shutdown` goes to 0 and `restart` goes to 1.
- R7: `restart` is high for exactly one clock and only on the exit from shutdown.
- R8: A burst of current-limit ticks whose integrated level stays below `cfg_hi` never asserts `shutdown`. The configuration must satisfy `cfg_lo` < `cfg_hi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-clock strobe per oscillator cycle |
| ilim_hit | input | 1 | Current limit fired in this cycle (sampled with tick) |
| cfg_step | input | ACC_W | Charge quantum per current-limit tick |
| cfg_leak | input | ACC_W | Drain per tick |
| cfg_hi | input | ACC_W | Shutdown threshold |
| cfg_lo | input | ACC_W | Restart threshold |
| level | output | ACC_W | Integrator value |
| shutdown | output | 1 | Switching disabled |
| restart | output | 1 | One-clock soft-start request |

## Verification
Every result of a tick is due exactly one clock later. The new `level`, any change of `shutdown`, and the `restart` pulse all appear together on the registers loaded at the tick edge. The bench drives inputs at the falling edge, lets one rising edge pass, and compares all three outputs at the next falling edge against a reference model stepped once per clock. Cycles without a tick are checked the same way, so holding behaviour and the single-clock width of `restart` are compared cycle by cycle.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
   typedef enum logic {
      MODE_RUN  = 1'b0,
      MODE_HALT = 1'b1
   } hiccup_mode_e;

   localparam int unsigned ORDER_CHARGE_FIRST = 0;
   localparam int unsigned ORDER_LEAK_FIRST   = 1;
endpackage

// File: rtl/hiccup_sat_step.sv
module hiccup_sat_step #(
   parameter int unsigned ACC_W = 12,
   parameter int unsigned ORDER = 0
) (
   input  logic [ACC_W-1:0] cur,
   input  logic             add_en,
   input  logic [ACC_W-1:0] step,
   input  logic [ACC_W-1:0] leak,
   output logic [ACC_W-1:0] nxt
);
   import hiccup_pkg::*;

   localparam logic [ACC_W-1:0] FULL = {ACC_W{1'b1}};

   logic [ACC_W-1:0] inc;
   assign inc = add_en ? step : '0;

   function automatic logic [ACC_W-1:0] sadd(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
      logic [ACC_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[ACC_W] ? FULL : s[ACC_W-1:0];
   endfunction

   function automatic logic [ACC_W-1:0] ssub(input logic [ACC_W-1:0] a, input logic [ACC_W-1:0] b);
      return (a >= b) ? (a - b) : '0;
   endfunction

   generate
      if (ORDER == ORDER_CHARGE_FIRST) begin : g_charge_first
         logic [ACC_W-1:0] mid;
         always_comb begin
            mid = sadd(cur, inc);
            nxt = ssub(mid, leak);
         end
      end else if (ORDER == ORDER_LEAK_FIRST) begin : g_leak_first
         logic [ACC_W-1:0] mid;
         always_comb begin
            mid = ssub(cur, leak);
            nxt = sadd(mid, inc);
         end
      end else begin : g_bad_order
         $error("hiccup_sat_step: ORDER must be 0 or 1");
         assign nxt = cur;
      end
   endgenerate
endmodule

// File: rtl/hiccup_mode_fsm.sv
module hiccup_mode_fsm #(
   parameter int unsigned ACC_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [ACC_W-1:0] nxt,
   input  logic [ACC_W-1:0] hi,
   input  logic [ACC_W-1:0] lo,
   output logic             halted,
   output logic             restart_p
);
   import hiccup_pkg::*;

   hiccup_mode_e mode_q, mode_d;
   logic         rst_pulse_d;

   always_comb begin
      mode_d      = mode_q;
      rst_pulse_d = 1'b0;
      if (tick) begin
         unique case (mode_q)
            MODE_RUN: begin
               if (nxt >= hi) mode_d = MODE_HALT;
            end
            MODE_HALT: begin
               if (nxt <= lo) begin
                  mode_d      = MODE_RUN;
                  rst_pulse_d = 1'b1;
               end
            end
            default: mode_d = MODE_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_RUN;
         restart_p <= 1'b0;
      end else begin
         mode_q    <= mode_d;
         restart_p <= rst_pulse_d;
      end
   end

   assign halted = (mode_q == MODE_HALT);

   AST_RESTART_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      restart_p |-> (!halted && $past(halted))); // R6
   AST_RESTART_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      restart_p |=> !restart_p); // R7
   AST_NO_TICK_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(halted)); // R2
   AST_EXIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(halted) |-> $past(tick)); // R6
endmodule

// File: rtl/hiccup_integrator.sv
module hiccup_integrator #(
   parameter int unsigned ACC_W = 12,
   parameter int unsigned ORDER = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ilim_hit,
   input  logic [ACC_W-1:0] cfg_step,
   input  logic [ACC_W-1:0] cfg_leak,
   input  logic [ACC_W-1:0] cfg_hi,
   input  logic [ACC_W-1:0] cfg_lo,
   output logic [ACC_W-1:0] level,
   output logic             shutdown,
   output logic             restart
);
   if (ACC_W < 2) begin : g_chk_w
      $error("hiccup_integrator: ACC_W must be at least 2");
   end
   if (ORDER > 1) begin : g_chk_order
      $error("hiccup_integrator: ORDER must be 0 or 1");
   end

   logic [ACC_W-1:0] level_q;
   logic [ACC_W-1:0] level_nxt;
   logic             halted;
   logic             add_en;

   assign add_en = ilim_hit & ~halted;

   hiccup_sat_step #(.ACC_W(ACC_W), .ORDER(ORDER)) u_step (
      .cur    (level_q),
      .add_en (add_en),
      .step   (cfg_step),
      .leak   (cfg_leak),
      .nxt    (level_nxt)
   );

   hiccup_mode_fsm #(.ACC_W(ACC_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .nxt       (level_nxt),
      .hi        (cfg_hi),
      .lo        (cfg_lo),
      .halted    (halted),
      .restart_p (restart)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= '0;
      else if (tick) level_q <= level_nxt;
   end

   assign level    = level_q;
   assign shutdown = halted;

   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(level)); // R2
   AST_HALT_ONLY_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && tick) |=> (level <= $past(level))); // R5
   AST_HALT_AT_HI: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> (level >= cfg_hi)); // R4
   AST_RESTART_AT_LO: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> (level <= cfg_lo)); // R6
   AST_RUN_BELOW_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (!shutdown && !restart && $past(!shutdown)) |-> (level < cfg_hi)); // R8
endmodule

// File: tb/sim_hiccup_integrator.sv
module sim_hiccup_integrator;
   localparam int CLK_PERIOD = 10;
   localparam int W = 12;
   localparam logic [W-1:0] FULL = {W{1'b1}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic ilim_hit = 1'b0;
   logic [W-1:0] cfg_step = '0, cfg_leak = '0, cfg_hi = '0, cfg_lo = '0;
   logic [W-1:0] level;
   logic shutdown, restart;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_lvl = '0;
   logic m_halt = 1'b0;
   logic m_rst = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hiccup_integrator #(.ACC_W(W), .ORDER(0)) u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ilim_hit(ilim_hit),
      .cfg_step(cfg_step), .cfg_leak(cfg_leak), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
      .level(level), .shutdown(shutdown), .restart(restart)
   );

   function automatic logic [W-1:0] f_add(input logic [W-1:0] a, input logic [W-1:0] b);
      int s;
      s = int'(a) + int'(b);
      return (s > int'(FULL)) ? FULL : W'(s);
   endfunction

   function automatic logic [W-1:0] f_sub(input logic [W-1:0] a, input logic [W-1:0] b);
      return (a >= b) ? W'(a - b) : '0;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (level !== m_lvl || shutdown !== m_halt || restart !== m_rst) begin
         errors++;
         $display("FAIL %s: level=%0d shutdown=%0b restart=%0b expected level=%0d shutdown=%0b restart=%0b",
                  tag, level, shutdown, restart, m_lvl, m_halt, m_rst);
      end
   endtask

   task automatic cycle(input logic hit, input logic tk, input string force_tag);
      logic was_halt, was_rst;
      logic [W-1:0] nxt;
      string tag;
      was_halt = m_halt;
      was_rst  = m_rst;
      ilim_hit = hit;
      tick     = tk;
      @(posedge clk);
      m_rst = 1'b0;
      if (tk) begin
         nxt = f_sub(f_add(m_lvl, (hit && !m_halt) ? cfg_step : '0), cfg_leak);
         if (!m_halt && nxt >= cfg_hi) m_halt = 1'b1;
         else if (m_halt && nxt <= cfg_lo) begin
            m_halt = 1'b0;
            m_rst  = 1'b1;
         end
         m_lvl = nxt;
      end
      @(negedge clk);
      if (force_tag != "") tag = force_tag;
      else if (m_rst) tag = "R6";
      else if (was_rst) tag = "R7";
      else if (m_halt && !was_halt) tag = "R4";
      else if (was_halt) tag = "R5";
      else if (!tk) tag = "R2";
      else tag = "R3";
      check(tag);
   endtask

   task automatic restart_with(input logic [W-1:0] st, input logic [W-1:0] lk,
                               input logic [W-1:0] h, input logic [W-1:0] l);
      rst_n = 1'b0;
      tick = 1'b0;
      ilim_hit = 1'b0;
      cfg_step = st; cfg_leak = lk; cfg_hi = h; cfg_lo = l;
      m_lvl = '0; m_halt = 1'b0; m_rst = 1'b0;
      repeat (2) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));

      // Saturation at the top: step 3000 twice with no leak -> clamps at FULL, halts (R3, R4)
      restart_with(12'd3000, 12'd0, FULL, 12'd100);
      cycle(1'b1, 1'b1, "R3");
      cycle(1'b1, 1'b1, "R4");
      cycle(1'b1, 1'b0, "R2");

      // Floor at zero and transient tolerance below threshold (R3, R8)
      restart_with(12'd10, 12'd4, 12'd100, 12'd20);
      for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, "R8");
      for (int i = 0; i < 12; i++) cycle(1'b0, 1'b1, "R8");
      cycle(1'b0, 1'b1, "R3");

      // Full hiccup: charge to halt, hits ignored while draining, restart pulse (R4..R7)
      restart_with(12'd50, 12'd5, 12'd200, 12'd40);
      for (int i = 0; i < 6; i++) cycle(1'b1, 1'b1, "");
      for (int i = 0; i < 60; i++) cycle(1'b1, (i % 3) != 0, "");
      for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, "R2");

      // Constrained random configurations and stimulus
      for (int cfgn = 0; cfgn < 12; cfgn++) begin
         logic [W-1:0] h, st, lk, l;
         h  = W'(200 + ($urandom % 2800));
         l  = W'($urandom % int'(h));
         st = W'(1 + ($urandom % 300));
         lk = W'($urandom % 40);
         restart_with(st, lk, h, l);
         for (int i = 0; i < 800; i++)
            cycle(($urandom % 100) < 55, ($urandom % 100) < 70, "");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule